// File: doc/BRIEF.md
# True Dual-Port Dual-Clock RAM

This block is a parameterised memory with two read/write ports that are fully independent. Each port has its own clock, clock enable, write enable, address, write data and registered read data. On every rising edge of its own clock a port carries out one command, chosen by its two control inputs: idle, read or write. Reads and writes are both synchronous, so a read returns its word in the cycle after the edge that captured the address.

A write on a port also updates that port's own read output with the new data (write-first). When one port reads a word in the same window in which the other port is writing it, the read result is undefined. The window opens at the writing port's rising edge and can last until that port's next rising edge. When both ports write one word in overlapping windows, the word's content is undefined until it is written again. These collisions are left to the user of the block, who must avoid them or tolerate them.

The memory holds 2**ADDR_W words of DATA_W bits each. A structural parameter picks how the storage is built. The default keeps one bank per port and a per-word last-writer bit, so each storage element has exactly one clock. The other option is a single shared array that a synthesis tool maps onto a block RAM with two ports.

Top module: `tdp_ram`

## Requirements
- R1: While a port's clock enable is low, an edge of that port's clock leaves memory unchanged whatever its write enable is, and that port's read output holds its previous value.
- R2: With clock enable high and write enable low, the port loads the word at its address into its read output.
- R3: With clock enable high and write enable high, the port stores its write data at its address, and later reads of that address return it.
- R4: A port's read output changes only at that port's rising clock edge, one cycle after the command is presented; before that edge it still shows the previous value.
- R5: In the cycle after a write, the writing port's read output equals the data just written, including on consecutive writes.
- R6: The two ports run on unrelated clocks, and a word written through one port is read back through the other once the write window has closed. This holds while both ports are busy on disjoint addresses.
- R7: The whole address range of 2**ADDR_W words is reachable from both ports, and the lowest and highest words are distinct storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A |
| ce_a | input | 1 | Port A clock enable, gates every command |
| we_a | input | 1 | Port A write enable, 1 = write, 0 = read |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A registered read data |
| clk_b | input | 1 | Clock of port B |
| ce_b | input | 1 | Port B clock enable, gates every command |
| we_b | input | 1 | Port B write enable, 1 = write, 0 = read |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B registered read data |

## Verification
The hardest situation to reach is traffic on both ports at once, on clocks whose edges keep drifting against each other, with the results still defined. The bench runs port A at 8 ns and port B at 11.3 ns. It forks two writers on disjoint address ranges so their edges interleave in every phase, then forks two readers that each read the other port's range. A cross-port read-back is started only after the writer has completed further idle edges, so no checked read falls inside a collision window. Writes with the clock enable low are made to a word that holds a known value, and that word is then read back to show it did not change.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } tdp_cmd_e;

   function automatic tdp_cmd_e decode_cmd(input logic ce, input logic we);
      if (!ce)    return CMD_IDLE;
      else if (we) return CMD_WRITE;
      else        return CMD_READ;
   endfunction

endpackage

// File: rtl/tdp_ram_cmd_dec.sv
module tdp_ram_cmd_dec
   import tdp_ram_pkg::*;
(
   input  logic     ce,
   input  logic     we,
   output tdp_cmd_e cmd
);
   always_comb cmd = decode_cmd(ce, we);
endmodule

// File: rtl/tdp_ram_rdreg.sv
module tdp_ram_rdreg
   import tdp_ram_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  tdp_cmd_e          cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rdata
);
   // write-first: a write forwards its own data; idle holds the register
   always_ff @(posedge clk) begin
      case (cmd)
         CMD_WRITE: rdata <= wdata;
         CMD_READ:  rdata <= rd_word;
         default:   rdata <= rdata;
      endcase
   end
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
   import tdp_ram_pkg::*;
#(
   parameter int ADDR_W       = 6,
   parameter int DATA_W       = 16,
   parameter bit SHARED_ARRAY = 1'b0
) (
   input  logic              clk_a,
   input  logic              ce_a,
   input  logic              we_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [DATA_W-1:0] wdata_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic              clk_b,
   input  logic              ce_b,
   input  logic              we_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] wdata_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int NPORT = 2;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("tdp_ram: ADDR_W must lie in 1..16");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("tdp_ram: DATA_W must be positive");
   end

   logic              clk_p   [NPORT];
   logic              ce_p    [NPORT];
   logic              we_p    [NPORT];
   logic [DATA_W-1:0] wdata_p [NPORT];
   logic [DATA_W-1:0] rdata_p [NPORT];
   logic [DATA_W-1:0] rd_word [NPORT];
   tdp_cmd_e          cmd_p   [NPORT];

   assign clk_p[0]   = clk_a;
   assign clk_p[1]   = clk_b;
   assign ce_p[0]    = ce_a;
   assign ce_p[1]    = ce_b;
   assign we_p[0]    = we_a;
   assign we_p[1]    = we_b;
   assign wdata_p[0] = wdata_a;
   assign wdata_p[1] = wdata_b;
   assign rdata_a    = rdata_p[0];
   assign rdata_b    = rdata_p[1];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      tdp_ram_cmd_dec u_dec (
         .ce  (ce_p[p]),
         .we  (we_p[p]),
         .cmd (cmd_p[p])
      );
      tdp_ram_rdreg #(.DATA_W(DATA_W)) u_rdreg (
         .clk     (clk_p[p]),
         .cmd     (cmd_p[p]),
         .wdata   (wdata_p[p]),
         .rd_word (rd_word[p]),
         .rdata   (rdata_p[p])
      );
   end

   if (SHARED_ARRAY) begin : g_shared
      // one array, one process per clock: the form block RAM inference expects
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk_a) begin
         if (cmd_p[0] == CMD_WRITE) mem[addr_a] <= wdata_a;
      end
      always_ff @(posedge clk_b) begin
         if (cmd_p[1] == CMD_WRITE) mem[addr_b] <= wdata_b;
      end
      assign rd_word[0] = mem[addr_a];
      assign rd_word[1] = mem[addr_b];
   end else begin : g_banked
      // one bank per port plus a last-writer bit pair per word;
      // equal bits mean port A wrote last, differing bits mean port B
      logic [DATA_W-1:0] bank_a [DEPTH];
      logic [DATA_W-1:0] bank_b [DEPTH];
      logic [DEPTH-1:0]  own_a = '0;
      logic [DEPTH-1:0]  own_b = '0;

      always_ff @(posedge clk_a) begin
         if (cmd_p[0] == CMD_WRITE) begin
            bank_a[addr_a] <= wdata_a;
            own_a[addr_a]  <= own_b[addr_a];
         end
      end
      always_ff @(posedge clk_b) begin
         if (cmd_p[1] == CMD_WRITE) begin
            bank_b[addr_b] <= wdata_b;
            own_b[addr_b]  <= ~own_a[addr_b];
         end
      end
      assign rd_word[0] = (own_a[addr_a] == own_b[addr_a]) ? bank_a[addr_a] : bank_b[addr_a];
      assign rd_word[1] = (own_a[addr_b] == own_b[addr_b]) ? bank_a[addr_b] : bank_b[addr_b];
   end
endmodule

// File: rtl/tdp_ram_sva.sv
module tdp_ram_sva #(
   parameter int DATA_W = 16
) (
   input logic              clk_a,
   input logic              ce_a,
   input logic              we_a,
   input logic [DATA_W-1:0] wdata_a,
   input logic [DATA_W-1:0] rdata_a,
   input logic              clk_b,
   input logic              ce_b,
   input logic              we_b,
   input logic [DATA_W-1:0] wdata_b,
   input logic [DATA_W-1:0] rdata_b
);
   // the block has no reset; checks arm after the first edge of each clock
   logic arm_a = 1'b0;
   logic arm_b = 1'b0;
   always_ff @(posedge clk_a) arm_a <= 1'b1;
   always_ff @(posedge clk_b) arm_b <= 1'b1;

   p_hold_a_r1: assert property (@(posedge clk_a) disable iff (!arm_a)
      !ce_a |=> $stable(rdata_a));
   p_hold_b_r1: assert property (@(posedge clk_b) disable iff (!arm_b)
      !ce_b |=> $stable(rdata_b));
   p_wfirst_a_r5: assert property (@(posedge clk_a) disable iff (!arm_a)
      (ce_a && we_a) |=> (rdata_a == $past(wdata_a)));
   p_wfirst_b_r5: assert property (@(posedge clk_b) disable iff (!arm_b)
      (ce_b && we_b) |=> (rdata_b == $past(wdata_b)));
endmodule

bind tdp_ram tdp_ram_sva #(.DATA_W(DATA_W)) u_sva (
   .clk_a   (clk_a),
   .ce_a    (ce_a),
   .we_a    (we_a),
   .wdata_a (wdata_a),
   .rdata_a (rdata_a),
   .clk_b   (clk_b),
   .ce_b    (ce_b),
   .we_b    (we_b),
   .wdata_b (wdata_b),
   .rdata_b (rdata_b)
);

// File: tb/sim_tdp_ram.sv
`timescale 1ns/100ps
module sim_tdp_ram;
   localparam int AW  = 6;
   localparam int DW  = 16;
   localparam int TOP = (1 << AW) - 1;

   logic          clk_a = 1'b0, clk_b = 1'b0;
   logic          ce_a = 1'b0, we_a = 1'b0, ce_b = 1'b0, we_b = 1'b0;
   logic [AW-1:0] addr_a = '0, addr_b = '0;
   logic [DW-1:0] wdata_a = '0, wdata_b = '0;
   logic [DW-1:0] rdata_a, rdata_b;
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   always #4    clk_a = ~clk_a;   // 125 MHz
   always #5.65 clk_b = ~clk_b;   // unrelated period

   tdp_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk_a(clk_a), .ce_a(ce_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
      .clk_b(clk_b), .ce_b(ce_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic op_a(input logic ce, input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] q);
      @(negedge clk_a);
      ce_a = ce; we_a = we; addr_a = a; wdata_a = d;
      @(posedge clk_a);
      @(negedge clk_a);
      q = rdata_a;
      ce_a = 1'b0; we_a = 1'b0;
   endtask

   task automatic op_b(input logic ce, input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] q);
      @(negedge clk_b);
      ce_b = ce; we_b = we; addr_b = a; wdata_b = d;
      @(posedge clk_b);
      @(negedge clk_b);
      q = rdata_b;
      ce_b = 1'b0; we_b = 1'b0;
   endtask

   task automatic t_same_port;
      logic [DW-1:0] q;
      op_a(1, 1, 6'd5, 16'hA5C3, q); chk("R5 A write-first", q, 16'hA5C3);
      op_a(1, 0, 6'd5, 16'h0000, q); chk("R2/R3 A read-back", q, 16'hA5C3);
      op_b(1, 1, 6'd6, 16'h3C5A, q); chk("R5 B write-first", q, 16'h3C5A);
      op_b(1, 0, 6'd6, 16'h0000, q); chk("R2/R3 B read-back", q, 16'h3C5A);
   endtask

   task automatic t_latency;
      logic [DW-1:0] q;
      op_a(1, 1, 6'd7, 16'h1111, q);
      @(negedge clk_a);
      ce_a = 1'b1; we_a = 1'b0; addr_a = 6'd5;
      #1;
      chk("R4 A before edge", rdata_a, 16'h1111);
      @(posedge clk_a);
      @(negedge clk_a);
      chk("R4 A after edge", rdata_a, 16'hA5C3);
      ce_a = 1'b0;
   endtask

   task automatic t_ce_low;
      logic [DW-1:0] q;
      op_a(1, 0, 6'd5, 16'h0000, q);
      op_a(0, 1, 6'd5, 16'hFFFF, q); chk("R1 A output holds", q, 16'hA5C3);
      op_a(1, 0, 6'd5, 16'h0000, q); chk("R1 A word untouched", q, 16'hA5C3);
      op_b(1, 0, 6'd6, 16'h0000, q);
      op_b(0, 1, 6'd6, 16'h0F0F, q); chk("R1 B output holds", q, 16'h3C5A);
      op_b(1, 0, 6'd6, 16'h0000, q); chk("R1 B word untouched", q, 16'h3C5A);
   endtask

   task automatic t_back_to_back;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk_a);
         if (i > 0) chk("R5 A consecutive write", rdata_a, 16'hC000 + DW'(i - 1));
         ce_a = 1'b1; we_a = 1'b1; addr_a = 6'd9; wdata_a = 16'hC000 + DW'(i);
      end
      @(negedge clk_a);
      chk("R5 A consecutive write", rdata_a, 16'hC003);
      ce_a = 1'b0; we_a = 1'b0;
   endtask

   task automatic t_cross;
      logic [DW-1:0] q;
      op_a(1, 1, 6'd10, 16'hBEEF, q);
      repeat (2) @(posedge clk_a);
      op_b(1, 0, 6'd10, 16'h0000, q); chk("R6 A->B", q, 16'hBEEF);
      op_b(1, 1, 6'd20, 16'h1234, q);
      repeat (2) @(posedge clk_b);
      op_a(1, 0, 6'd20, 16'h0000, q); chk("R6 B->A", q, 16'h1234);
      op_b(1, 0, 6'd9, 16'h0000, q); chk("R6 B sees last A write", q, 16'hC003);
   endtask

   task automatic t_bounds;
      logic [DW-1:0] q;
      op_a(1, 1, AW'(TOP), 16'hAAAA, q);
      op_b(1, 1, 6'd0, 16'h5555, q);
      repeat (2) @(posedge clk_a);
      op_a(1, 0, 6'd0, 16'h0000, q);    chk("R7 A reads word 0", q, 16'h5555);
      op_b(1, 0, AW'(TOP), 16'h0000, q); chk("R7 B reads top word", q, 16'hAAAA);
      op_a(1, 0, AW'(TOP), 16'h0000, q); chk("R7 A reads top word", q, 16'hAAAA);
      op_b(1, 0, 6'd0, 16'h0000, q);    chk("R7 B reads word 0", q, 16'h5555);
   endtask

   task automatic t_concurrent;
      fork
         begin
            logic [DW-1:0] q;
            for (int i = 0; i < 8; i++) begin
               op_a(1, 1, AW'(32 + i), 16'hA000 + DW'(i), q);
               chk("R6 A busy write", q, 16'hA000 + DW'(i));
            end
         end
         begin
            logic [DW-1:0] q;
            for (int i = 0; i < 8; i++) begin
               op_b(1, 1, AW'(40 + i), 16'hB000 + DW'(i), q);
               chk("R6 B busy write", q, 16'hB000 + DW'(i));
            end
         end
      join
      repeat (2) @(posedge clk_b);
      fork
         begin
            logic [DW-1:0] q;
            for (int i = 0; i < 8; i++) begin
               op_a(1, 0, AW'(40 + i), 16'h0000, q);
               chk("R6 A reads B range", q, 16'hB000 + DW'(i));
            end
         end
         begin
            logic [DW-1:0] q;
            for (int i = 0; i < 8; i++) begin
               op_b(1, 0, AW'(32 + i), 16'h0000, q);
               chk("R6 B reads A range", q, 16'hA000 + DW'(i));
            end
         end
      join
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk_a);
      t_same_port();
      t_latency();
      t_ce_low();
      t_back_to_back();
      t_cross();
      t_bounds();
      t_concurrent();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule